// File: doc/BRIEF.md
# Watchdog Timer with Encoded Timeout Byte

This block is a watchdog timer paced by a 16 Hz tick enable that arrives as a one-cycle strobe. Software programs a single configuration byte that carries both the timeout and the action to take on expiry. Any write to that byte, or any read of it, restarts the countdown. If the countdown runs out, the block raises a sticky expiry flag. It then either pulses an interrupt or requests a system reset, as the steering bit selects.

The timeout is a 5-bit multiplier scaled by a power of four, so one byte covers intervals from one sixteenth of a second up to about two minutes. A reset-steered expiry also clears the configuration byte. It clears one bit of a neighbouring auxiliary control byte as well, which this block holds at select 1. Generating the tick and acting on the reset request are left to the surrounding chip.

Top module: `wdt_enc_top`

## Requirements
- R1: The configuration byte (select 0) encodes the timeout as bits [6:2] (multiplier) times 4 to the power of bits [1:0] (resolution), counted in tick strobes. The block expires at the edge where the tick completing that count is taken, and the pulse and flag are visible from the following cycle.
- R2: The countdown advances only in cycles where `tick_en` is high; any number of cycles without a tick never causes expiry.
- R3: A configuration byte of zero, or one whose multiplier field is zero, disables the watchdog: no flag and no pulse, however many ticks arrive.
- R4: A write to select 0 stores the byte so that it reads back unchanged, clears the expiry flag and restarts the countdown from the full new timeout.
- R5: A read of select 0 returns the stored byte on `acc_rdata`, clears the expiry flag and restarts the countdown from the full timeout.
- R6: On expiry, bit 7 of `flags_o` becomes 1 and stays 1 until the next access to select 0; bits [6:0] of `flags_o` are always 0.
- R7: When bit 7 of the configuration byte is 0 at expiry, `irq_pulse` is high for exactly one cycle and `rst_req` stays low.
- R8: When bit 7 of the configuration byte is 1 at expiry, `rst_req` is high for exactly one cycle and `irq_pulse` stays low. The configuration byte is cleared to 0x00, and bit 6 of the auxiliary byte (select 1) is cleared while its other bits are kept.
- R9: After an expiry the countdown is stopped: further ticks produce no further pulse until select 0 is accessed again.
- R10: After reset both bytes read 0x00, `flags_o` is 0x00 and both pulse outputs are low.
- R11: The auxiliary byte at select 1 is read and written as plain storage, and accessing it neither restarts nor disturbs the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle 16 Hz timebase strobe |
| acc_wr | input | 1 | Write strobe for the selected byte |
| acc_rd | input | 1 | Read strobe for the selected byte |
| acc_sel | input | 1 | Byte select: 0 configuration, 1 auxiliary |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data of the selected byte |
| flags_o | output | 8 | Flags byte, bit 7 is the sticky expiry flag |
| irq_pulse | output | 1 | One-cycle interrupt on steered expiry |
| rst_req | output | 1 | One-cycle system reset request on steered expiry |

## Verification
The bench walks a table of configuration bytes and checks each boundary. One tick short of the computed timeout, nothing may have happened. At the tick that completes the timeout, the expiry must appear. A design that decoded the resolution as a power of two, or that counted off by one, fails at exactly that boundary. Zero-multiplier encodings with a nonzero resolution are covered, as is a steering bit set on a zero multiplier; a design that treated either as a short timeout fires where it must stay silent. Directed tests then cover several cases: a read landing mid-count, which must push expiry out by a full interval; further ticks after an expiry, where a counter that wraps would pulse again; and auxiliary accesses that must leave the countdown alone.

// File: rtl/wdt_enc_pkg.sv
// Package: shared widths, byte layout and timeout decode for the encoded watchdog.
// Assumes an 8-bit configuration byte: steering bit on top, multiplier, then resolution.
package wdt_enc_pkg;

    parameter int DATA_W  = 8;
    parameter int MULT_W  = 5;
    parameter int RES_W   = 2;

    localparam int MULT_LSB  = RES_W;
    localparam int STEER_BIT = MULT_LSB + MULT_W;
    localparam int AUX_CLR_BIT = 6;
    // Widest count: multiplier shifted by twice the largest resolution code.
    localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1);

    typedef enum logic {
        SEL_CFG = 1'b0,
        SEL_AUX = 1'b1
    } byte_sel_e;

    // Number of tick strobes encoded by a configuration byte (0 means disabled).
    function automatic logic [CNT_W-1:0] cfg_to_ticks(input logic [DATA_W-1:0] cfg);
        logic [CNT_W-1:0] mult_ext;
        logic [RES_W-1:0] res;
        mult_ext = {{(CNT_W-MULT_W){1'b0}}, cfg[MULT_LSB +: MULT_W]};
        res      = cfg[RES_W-1:0];
        return mult_ext << {res, 1'b0};
    endfunction

endpackage

// File: rtl/wdt_countdown.sv
// Module: tick-paced down counter. Loads a count, decrements on each tick strobe,
// reports expiry on the tick that reaches the end and then stops until reloaded.
// Assumes a load value of zero means "disabled"; a load wins over a same-cycle tick.
module wdt_countdown #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Expiry fires on the tick that consumes the last remaining count.
    assign expire = run_q && tick_en && !load && (cnt_q == CNT_W'(1));

    // Counter state: reload on restart, stop on expiry, step down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            run_q <= (load_val != '0);
        end else if (expire) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (run_q && tick_en) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    p_dec_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick_en && !load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load) |=> $stable(cnt_q));

    p_zero_disables_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> !run_q);

    p_stop_after_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !run_q);

endmodule

// File: rtl/wdt_action.sv
// Module: expiry action. Keeps the sticky expiry flag and turns an expiry into
// exactly one registered interrupt or reset-request pulse.
// Assumes clear and expire never coincide (a restart suppresses expiry upstream).
module wdt_action (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic steer_rst,
    input  logic clear,
    output logic flag_q,
    output logic irq_q,
    output logic rst_q
);

    // Sticky flag: set by expiry, cleared by a restart of the watchdog.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (clear) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end
    end

    // Pulse outputs: one cycle, routed by the steering bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            irq_q <= expire && !steer_rst;
            rst_q <= expire && steer_rst;
        end
    end

    p_one_action_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_q && rst_q));

    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    p_rst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |=> !rst_q);

    p_flag_with_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q || rst_q) |-> flag_q);

endmodule

// File: rtl/wdt_regs.sv
// Module: byte storage for the configuration and auxiliary bytes.
// A reset-steered expiry clears the configuration byte and one auxiliary bit.
// Assumes a configuration write never coincides with an expiry.
module wdt_regs
    import wdt_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  byte_sel_e         sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hit_reset,
    output logic [DATA_W-1:0] cfg_q,
    output logic [DATA_W-1:0] aux_q
);

    // Configuration byte: software write, cleared by a reset-steered expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (hit_reset) begin
            cfg_q <= '0;
        end else if (wr && sel == SEL_CFG) begin
            cfg_q <= wdata;
        end
    end

    // Auxiliary byte: plain storage with one bit knocked down on reset expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_q <= '0;
        end else begin
            logic [DATA_W-1:0] nxt;
            nxt = aux_q;
            if (wr && sel == SEL_AUX) nxt = wdata;
            if (hit_reset) nxt[AUX_CLR_BIT] = 1'b0;
            aux_q <= nxt;
        end
    end

    p_cfg_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_reset |=> (cfg_q == '0));

    p_aux_bit_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_reset |=> !aux_q[AUX_CLR_BIT]);

endmodule

// File: rtl/wdt_enc_top.sv
// Module: watchdog with an encoded timeout byte. Any access to the configuration
// byte restarts the countdown; expiry raises a sticky flag and one pulse.
// Assumes tick_en is a one-cycle strobe at the watchdog timebase rate.
module wdt_enc_top
    import wdt_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic              acc_sel,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic [DATA_W-1:0] flags_o,
    output logic              irq_pulse,
    output logic              rst_req
);

    byte_sel_e         sel;
    logic              restart;
    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] aux_q;
    logic [DATA_W-1:0] load_cfg;
    logic [CNT_W-1:0]  load_ticks;
    logic              expire;
    logic              hit_reset;
    logic              flag_q;

    // Access decode: restart on either access to the configuration byte.
    always_comb begin
        sel      = byte_sel_e'(acc_sel);
        restart  = (acc_wr || acc_rd) && (sel == SEL_CFG);
        load_cfg = (acc_wr && sel == SEL_CFG) ? acc_wdata : cfg_q;
    end

    assign load_ticks = cfg_to_ticks(load_cfg);
    assign hit_reset  = expire && cfg_q[STEER_BIT];

    wdt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (acc_wr),
        .sel       (sel),
        .wdata     (acc_wdata),
        .hit_reset (hit_reset),
        .cfg_q     (cfg_q),
        .aux_q     (aux_q)
    );

    wdt_countdown #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (restart),
        .load_val (load_ticks),
        .expire   (expire)
    );

    wdt_action u_action (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .steer_rst (cfg_q[STEER_BIT]),
        .clear     (restart),
        .flag_q    (flag_q),
        .irq_q     (irq_pulse),
        .rst_q     (rst_req)
    );

    // Read mux and flags byte assembly.
    always_comb begin
        acc_rdata = (sel == SEL_AUX) ? aux_q : cfg_q;
        flags_o   = {flag_q, {(DATA_W-1){1'b0}}};
    end

    p_restart_clears_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !flags_o[DATA_W-1]);

    p_aux_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[DATA_W-1] && sel == SEL_AUX && !restart) |=> flags_o[DATA_W-1]);

endmodule

// File: tb/wdt_enc_top_tb.sv
module wdt_enc_top_tb_top;

    localparam int CLK_P = 10;
    localparam int NV = 9;
    localparam logic [7:0] V_CFG [NV] = '{8'h04, 8'h05, 8'h7C, 8'h0E, 8'h0B,
                                          8'h83, 8'h00, 8'h88, 8'hFF};
    localparam int V_TICKS [NV] = '{1, 4, 31, 48, 128, 0, 0, 2, 1984};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic acc_wr = 1'b0;
    logic acc_rd = 1'b0;
    logic acc_sel = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic [7:0] flags_o;
    logic irq_pulse;
    logic rst_req;

    int n_chk = 0;
    int n_fail = 0;
    int irq_seen = 0;
    int rst_seen = 0;

    always #(CLK_P/2) clk = ~clk;

    wdt_enc_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .acc_wr    (acc_wr),
        .acc_rd    (acc_rd),
        .acc_sel   (acc_sel),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .flags_o   (flags_o),
        .irq_pulse (irq_pulse),
        .rst_req   (rst_req)
    );

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (irq_pulse) irq_seen++;
        if (rst_req) rst_seen++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        acc_wr = 1'b1; acc_sel = sel; acc_wdata = d;
        @(posedge clk);
        @(negedge clk);
        acc_wr = 1'b0;
        #1;
    endtask

    task automatic do_read(input logic sel, output logic [7:0] d);
        @(negedge clk);
        acc_rd = 1'b1; acc_sel = sel;
        #1 d = acc_rdata;
        @(posedge clk);
        @(negedge clk);
        acc_rd = 1'b0;
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            tick_en = 1'b0;
        end
        #1;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int bi, br;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R10 reset state
        check(flags_o == 8'h00 && !irq_pulse && !rst_req, "R10", flags_o, 0);
        do_read(1'b0, rd); check(rd == 8'h00, "R10 cfg", rd, 0);
        do_read(1'b1, rd); check(rd == 8'h00, "R10 aux", rd, 0);

        // Table walk: R1, R3, R6, R7, R8, R9
        for (int v = 0; v < NV; v++) begin
            do_write(1'b1, 8'hFF);
            do_write(1'b0, V_CFG[v]);
            do_read(1'b0, rd);
            check(rd == V_CFG[v], "R4 readback", rd, V_CFG[v]);
            bi = irq_seen; br = rst_seen;
            if (V_TICKS[v] == 0) begin
                ticks(300);
                check(flags_o == 8'h00, "R3 flag", flags_o, 0);
                check(irq_seen == bi && rst_seen == br, "R3 pulses", irq_seen - bi + rst_seen - br, 0);
            end else begin
                ticks(V_TICKS[v] - 1);
                check(flags_o == 8'h00, "R1 early", flags_o, 0);
                check(irq_seen == bi && rst_seen == br, "R1 early pulse", irq_seen - bi + rst_seen - br, 0);
                ticks(1);
                check(flags_o == 8'h80, "R6 flag", flags_o, 8'h80);
                if (V_CFG[v][7]) begin
                    check(rst_seen - br == 1 && irq_seen == bi, "R8 pulse", rst_seen - br, 1);
                end else begin
                    check(irq_seen - bi == 1 && rst_seen == br, "R7 pulse", irq_seen - bi, 1);
                end
                ticks(8);
                check(irq_seen + rst_seen - bi - br == 1, "R9 stopped", irq_seen + rst_seen - bi - br, 1);
                check(flags_o == 8'h80, "R6 sticky", flags_o, 8'h80);
                do_read(1'b0, rd);
                if (V_CFG[v][7]) begin
                    check(rd == 8'h00, "R8 cfg cleared", rd, 0);
                    do_read(1'b1, rd);
                    check(rd == 8'hBF, "R8 aux bit6", rd, 8'hBF);
                end else begin
                    check(rd == V_CFG[v], "R7 cfg kept", rd, V_CFG[v]);
                end
            end
        end

        // R2: no ticks, no progress
        do_write(1'b0, 8'h04);
        repeat (50) @(negedge clk);
        #1 check(flags_o == 8'h00, "R2 idle", flags_o, 0);
        ticks(1);
        check(flags_o == 8'h80, "R2 one tick", flags_o, 8'h80);

        // R4: write clears the flag
        do_write(1'b0, 8'h00);
        check(flags_o == 8'h00, "R4 clear", flags_o, 0);

        // R5: read mid-count restarts
        do_write(1'b0, 8'h10);
        ticks(3);
        do_read(1'b0, rd);
        check(rd == 8'h10, "R5 data", rd, 8'h10);
        ticks(3);
        check(flags_o == 8'h00, "R5 restarted", flags_o, 0);
        bi = irq_seen;
        ticks(1);
        check(flags_o == 8'h80 && irq_seen - bi == 1, "R5 expiry", flags_o, 8'h80);
        do_read(1'b0, rd);
        check(flags_o == 8'h00, "R5 clear", flags_o, 0);
        ticks(4);
        check(irq_seen - bi == 2, "R5 rearmed", irq_seen - bi, 2);

        // R11: aux access leaves countdown alone
        do_write(1'b0, 8'h10);
        ticks(2);
        do_write(1'b1, 8'h5A);
        do_read(1'b1, rd);
        check(rd == 8'h5A, "R11 aux data", rd, 8'h5A);
        ticks(2);
        check(flags_o == 8'h80, "R11 no restart", flags_o, 8'h80);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule